// File: doc/BRIEF.md
# Programmable Counter/Timer with Encoded Clock Source

A 16-bit down-counter for a serial-port peripheral. It runs in one of two ways. In counter mode it counts down once from a 16-bit preload and raises a ready flag when it reaches zero. In timer mode it runs freely and produces a square wave whose half-period is the preload, measured in ticks of the selected clock.

A single 3-bit mode code sets both the mode and the clock source. The sources are an external pin, the transmitter's 1x clock and the crystal clock, and some codes add a divide-by-16. One code is reserved and leaves the block idle. All three sources arrive as pins that are asynchronous to the system clock. They are synchronized and counted on their rising edges, and nothing runs on a derived clock.

Software writes the preload one byte at a time and writes the mode code. It then issues start and stop commands and reads the live count.

Top module: `ctmr`

## Requirements
- R1: After reset, `count` is 0, `sq_out` is 0, `ready` is 0 and the mode code is 000.
- R2: A write with `wr_sel`=00 stores `wr_data` as the low preload byte, 01 stores it as the high byte, and 10 stores `wr_data[2:0]` as the mode code. A preload write never alters a count that is already in progress; the new value takes effect at the next start or reload.
- R3: The mode codes select the tick source as follows: 000 `ext_clk`, 001 `txc_clk`, 011 `xtal_clk`/16, 100 `ext_clk`, 101 `ext_clk`/16, 110 `xtal_clk`, 111 `xtal_clk`/16. Rising edges on pins that are not selected have no effect.
- R4: With code 010, no source produces ticks and a start command is ignored, so `count` and `sq_out` hold.
- R5: A divided source gives exactly one tick per 16 rising edges. Writing the mode code or issuing a start restarts the divide-by-16 sequence.
- R6: Codes 000, 001 and 011 are counter mode. A start loads the preload, each tick lowers `count` by one, and when `count` reaches zero `ready` sets and counting stops with `count` held at 0.
- R7: Codes 1xx are timer mode. Each tick that finds `count` at 1 or 0 reloads the preload, inverts `sq_out` and sets `ready`; any other tick decrements. The wave period is therefore twice the preload.
- R8: A stop command clears `ready`. A start command clears `ready` and `sq_out`. Stop takes priority over a tick that would set `ready` in the same cycle.
- R9: A rising edge on the selected pin changes `count` on the third rising edge of `clk` after the pin goes high.
- R10: In counter mode, `sq_out` changes only through a start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 preload low, 01 preload high, 10 mode |
| wr_data | input | 8 | Write data |
| start | input | 1 | Load preload and begin |
| stop | input | 1 | Clear ready flag |
| ext_clk | input | 1 | External count pin (asynchronous) |
| txc_clk | input | 1 | Transmitter 1x clock (asynchronous) |
| xtal_clk | input | 1 | Crystal clock (asynchronous) |
| count | output | 16 | Current count value |
| sq_out | output | 1 | Timer square wave |
| ready | output | 1 | Terminal-count flag |

## Verification
Commands act on the next `clk` edge. A pin edge reaches `count` on the third `clk` edge after the pin rises, because it passes through two synchronizer flops and an edge-detect flop. The bench checks this latency once, sampling at the falling edges after the second and the third rising edge. Every other tick is driven as a pin pulse that is held high for four cycles and then low for four, and all results are sampled at a falling edge after the pulse has settled. For the divided sources, the bench applies 16 pulses per expected tick and computes the expected count and wave phase from the tick number, the preload and the mode.

// File: rtl/ctmr.sv
`timescale 1ns/1ps
module ctmr #(
  parameter int DIVN = 16,
  parameter int SYNC_W = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [7:0]  wr_data,
  input  logic        start,
  input  logic        stop,
  input  logic        ext_clk,
  input  logic        txc_clk,
  input  logic        xtal_clk,
  output logic [15:0] count,
  output logic        sq_out,
  output logic        ready
);
  localparam int PSW = $clog2(DIVN);

  logic [2:0]        mode;
  logic [15:0]       preload;
  logic [PSW-1:0]    psc;
  logic              run;
  logic [SYNC_W-1:0] sy_ext, sy_txc, sy_xt;
  logic [2:0]        rise;
  logic              src_rise, use_div, tick, timer, reserved, start_ok, mode_wr, at_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy_ext <= '0; sy_txc <= '0; sy_xt <= '0;
    end else begin
      sy_ext <= {sy_ext[SYNC_W-2:0], ext_clk};
      sy_txc <= {sy_txc[SYNC_W-2:0], txc_clk};
      sy_xt  <= {sy_xt[SYNC_W-2:0], xtal_clk};
    end

  assign rise = {sy_xt[SYNC_W-2] & ~sy_xt[SYNC_W-1],
                 sy_txc[SYNC_W-2] & ~sy_txc[SYNC_W-1],
                 sy_ext[SYNC_W-2] & ~sy_ext[SYNC_W-1]};

  always_comb
    case (mode)
      3'b000, 3'b100, 3'b101: src_rise = rise[0];
      3'b001:                 src_rise = rise[1];
      3'b011, 3'b110, 3'b111: src_rise = rise[2];
      default:                src_rise = 1'b0;
    endcase

  assign use_div  = mode[0] & (mode[1] | mode[2]);
  assign timer    = mode[2];
  assign reserved = (mode == 3'b010);
  assign start_ok = start & ~reserved;
  assign mode_wr  = wr_en & (wr_sel == 2'b10);
  assign tick     = src_rise & (~use_div | (psc == PSW'(DIVN - 1)));
  assign at_end   = (count <= 16'd1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode <= 3'b000; preload <= '0;
    end else if (wr_en) begin
      case (wr_sel)
        2'b00:   preload[7:0]  <= wr_data;
        2'b01:   preload[15:8] <= wr_data;
        2'b10:   mode          <= wr_data[2:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) psc <= '0;
    else if (mode_wr || start_ok) psc <= '0;
    else if (src_rise && use_div) psc <= (psc == PSW'(DIVN - 1)) ? '0 : psc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count <= '0; sq_out <= 1'b0; run <= 1'b0;
    end else if (start_ok) begin
      count <= preload; sq_out <= 1'b0; run <= ~timer;
    end else begin
      if (mode_wr) run <= 1'b0;
      if (tick && timer) begin
        if (at_end) begin
          count <= preload; sq_out <= ~sq_out;
        end else count <= count - 1'b1;
      end else if (tick && run) begin
        if (at_end) begin
          count <= '0; run <= 1'b0;
        end else count <= count - 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ready <= 1'b0;
    else if (stop || start_ok) ready <= 1'b0;
    else if (tick && at_end && (timer || run)) ready <= 1'b1;
endmodule

// File: rtl/ctmr_chk.sv
`timescale 1ns/1ps
module ctmr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        stop,
  input logic        wr_en,
  input logic [1:0]  wr_sel,
  input logic [2:0]  mode,
  input logic [15:0] count,
  input logic        sq_out,
  input logic        ready
);
  logic mode_wr;
  assign mode_wr = wr_en && wr_sel == 2'b10;

  always_comb
    if (!rst_n) a_r1_reset_values: assert (count == 16'd0 && !sq_out && !ready && mode == 3'b000);

  a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !ready);

  a_r4_reserved_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b010) |=> $stable(count) && $stable(sq_out));

  a_r6_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[2] && !start) |=> (count == $past(count) || count == $past(count) - 16'd1));

  a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[2] && !start && count == 16'd0) |=> count == 16'd0);

  a_r10_sq_counter: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[2] && !start) |=> $stable(sq_out));
endmodule

bind ctmr ctmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .wr_en(wr_en),
  .wr_sel(wr_sel), .mode(mode), .count(count), .sq_out(sq_out), .ready(ready)
);

// File: tb/test_ctmr.sv
`timescale 1ns/1ps
module test_ctmr;
  logic clk = 0, rst_n = 0, wr_en = 0, start = 0, stop = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] pins = 0;
  logic [15:0] count;
  logic sq_out, ready;
  int checks = 0, errors = 0;
  bit done = 0;

  ctmr i_ctmr (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .start(start), .stop(stop), .ext_clk(pins[0]), .txc_clk(pins[1]), .xtal_clk(pins[2]),
    .count(count), .sq_out(sq_out), .ready(ready));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic go();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic pulse(int p, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pins[p] = 1; repeat (4) @(negedge clk);
      pins[p] = 0; repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hang expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cpin[3] = '{0, 1, 2};
    int cdiv[3] = '{1, 1, 16};
    logic [2:0] ccode[3] = '{3'b000, 3'b001, 3'b011};
    logic [2:0] tcode[4] = '{3'b100, 3'b101, 3'b110, 3'b111};
    int tpin[4] = '{0, 0, 2, 2};
    int tdiv[4] = '{1, 16, 1, 16};
    int c0, s0;
    repeat (3) @(negedge clk);
    chk("R1 count", count, 0); chk("R1 sq", sq_out, 0); chk("R1 ready", ready, 0);
    rst_n = 1;

    // R9 latency, R1 default mode 000 uses ext_clk
    wr(0, 8'd5); go();
    chk("R2 load", count, 5);
    @(negedge clk); pins[0] = 1;
    @(negedge clk); @(negedge clk); chk("R9 before", count, 5);
    @(negedge clk); chk("R9 due", count, 4);
    pins[0] = 0; repeat (4) @(negedge clk);

    // R2 preload write does not disturb a running count
    wr(0, 8'h55); wr(1, 8'h00);
    chk("R2 no disturb", count, 4);
    wr(1, 8'h01); wr(0, 8'h02); go();
    chk("R2 high byte", count, 258);

    // R3 R5 R6 counter sweep
    for (int m = 0; m < 3; m++) begin
      wr(2, {5'd0, ccode[m]}); wr(1, 0); wr(0, 3); go();
      pulse((cpin[m] + 1) % 3, 16); pulse((cpin[m] + 2) % 3, 16);
      chk("R3 unselected ignored", count, 3);
      for (int k = 1; k <= 4; k++) begin
        if (cdiv[m] > 1) begin
          pulse(cpin[m], cdiv[m] - 1);
          chk("R5 no tick before 16th", count, (k - 1) >= 3 ? 0 : 3 - (k - 1));
          pulse(cpin[m], 1);
        end else pulse(cpin[m], 1);
        chk("R6 count", count, k >= 3 ? 0 : 3 - k);
        chk("R6 ready", ready, k >= 3 ? 1 : 0);
        chk("R10 sq", sq_out, 0);
      end
      @(negedge clk); stop = 1; @(negedge clk); stop = 0;
      chk("R8 stop", ready, 0);
    end

    // R3 R5 R7 timer sweep
    for (int m = 0; m < 4; m++) begin
      int p = (tdiv[m] > 1) ? 2 : 3;
      int n = (tdiv[m] > 1) ? 3 : 7;
      wr(2, {5'd0, tcode[m]}); wr(1, 0); wr(0, p[7:0]); go();
      chk("R8 start clears", ready, 0);
      pulse(1, 2);
      chk("R3 txc ignored", count, p);
      for (int k = 1; k <= n; k++) begin
        pulse(tpin[m], tdiv[m]);
        chk("R7 count", count, p - (k % p));
        chk("R7 sq", sq_out, (k / p) % 2);
        chk("R7 ready", ready, k >= p ? 1 : 0);
      end
    end

    // R4 reserved code
    c0 = count; s0 = sq_out;
    wr(2, 8'd2); go();
    pulse(0, 2); pulse(1, 2); pulse(2, 17);
    chk("R4 count", count, c0); chk("R4 sq", sq_out, s0);
    chk("R4 start ignored ready", ready, 1);
    @(negedge clk); stop = 1; @(negedge clk); stop = 0;
    chk("R8 stop", ready, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule